// File: doc/BRIEF.md
# Per-Gun Palette Color Lookup

This block turns a stream of logical pixels into physical colors for two display paths. A wide palette holds 8 bits per gun and drives a 24-bit color. A narrow palette holds 4 bits per gun and drives a 12-bit color. Each palette is split into three independent gun RAMs (red, green, blue). Every gun RAM is indexed separately. In 4bpp and 8bpp modes all three guns use the same index. In 16bpp mode each gun takes its own overlapping byte of the pixel, so a suitable palette load gives 5:6:5, 5:5:5, 4:8:4 and similar packings.

A CPU port reaches the palettes. Each write carries a space select, which aims it at the wide palette, at the narrow palette, or at both. The data word always uses the 8-bit-per-gun layout, and the narrow palette keeps only the upper nibble of each gun byte. Reads name a single palette and return one cycle later. Pixel lookups also have one cycle of latency, and a valid flag is delayed to match them.

Top module: `pal_lookup`

## Requirements
- R1: While reset is asserted and immediately after it, `color_valid_o`, `vga_color_o`, `lcd_color_o` and `cpu_rdata_o` are all zero.
- R2: With mode 00 (4bpp), all three guns of both palettes are indexed by pixel[3:0], and pixel[15:4] has no effect.
- R3: With mode 01 (8bpp), all three guns of both palettes are indexed by pixel[7:0].
- R4: With mode 10 (16bpp), red is indexed by pixel[15:8], green by pixel[11:4] and blue by pixel[7:0], in both palettes.
- R5: Mode 11 behaves exactly like mode 01.
- R6: `color_valid_o` equals `pix_valid_i` from the previous cycle. The color outputs update only after a cycle with `pix_valid_i` high, and hold their value otherwise.
- R7: A write with space 00 stores `{red[23:16], green[15:8], blue[7:0]}` at the entry in the wide palette, and leaves the narrow palette unchanged.
- R8: A write with space 01 stores bits {23:20, 15:12, 7:4} of the word as the red, green and blue nibbles of the narrow entry, and leaves the wide palette unchanged.
- R9: A write with space 10 updates both palettes in the same cycle, using the formats of R7 and R8.
- R10: A write with space 11 changes neither palette.
- R11: A read returns its data on `cpu_rdata_o` one cycle later. Space 00 returns the wide entry. Space 01 returns `{r4,4'h0,g4,4'h0,b4,4'h0}`. Spaces 1x return zero. `cpu_rdata_o` holds its value between reads. A read and a write to the same entry in the same cycle return the old data.
- R12: A pixel lookup of an entry that is being written in the same cycle returns the entry's old data.
- R13: `lcd_color_o` is `{red4, green4, blue4}` from the narrow palette, using the same per-gun indices as `vga_color_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Pixel depth: 00=4bpp, 01=8bpp, 10=16bpp, 11=as 8bpp |
| pix_valid_i | input | 1 | Pixel on `pix_i` is to be looked up |
| pix_i | input | 16 | Logical pixel |
| color_valid_o | output | 1 | Colors on the outputs are from a new lookup |
| vga_color_o | output | 24 | Wide color {red, green, blue} |
| lcd_color_o | output | 12 | Narrow color {red, green, blue} |
| cpu_we_i | input | 1 | Palette write strobe |
| cpu_re_i | input | 1 | Palette read strobe |
| cpu_space_i | input | 2 | Address space select |
| cpu_idx_i | input | 8 | Palette entry index |
| cpu_wdata_i | input | 24 | Write word {red, green, blue} |
| cpu_rdata_o | output | 24 | Read word, valid the cycle after a read |

## Verification
The hardest case to reach is a same-cycle collision. A pixel lookup, or a CPU read, lands on the very entry that a write is changing, and in 16bpp the collision may hit only one gun. Random traffic over 256 entries seldom lines these up. The bench therefore forces them with directed cycles that reuse the write index as the pixel and read index. It also shrinks the random index range to a few entries in one phase, so that collisions become frequent in every mode.

// File: rtl/pal_pkg.sv
package pal_pkg;
  typedef enum logic [1:0] {
    MODE_4  = 2'b00,
    MODE_8  = 2'b01,
    MODE_16 = 2'b10,
    MODE_RS = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    SP_WIDE   = 2'b00,
    SP_NARROW = 2'b01,
    SP_BOTH   = 2'b10,
    SP_NONE   = 2'b11
  } space_e;

  localparam int unsigned NGUNS = 3;  // 0=blue, 1=green, 2=red
  localparam int unsigned LOW_BPP = 4;
endpackage

// File: rtl/pal_index.sv
module pal_index
  import pal_pkg::*;
#(
  parameter int unsigned PIX_W = 16,
  parameter int unsigned IDX_W = 8
) (
  input  mode_e              mode_i,
  input  logic [PIX_W-1:0]   pix_i,
  output logic [IDX_W-1:0]   r_idx_o,
  output logic [IDX_W-1:0]   g_idx_o,
  output logic [IDX_W-1:0]   b_idx_o
);
  localparam int unsigned G_LSB = (PIX_W - IDX_W) / 2;

  always_comb begin
    case (mode_i)
      MODE_4: begin
        r_idx_o = IDX_W'(pix_i[LOW_BPP-1:0]);
        g_idx_o = IDX_W'(pix_i[LOW_BPP-1:0]);
        b_idx_o = IDX_W'(pix_i[LOW_BPP-1:0]);
      end
      MODE_16: begin
        r_idx_o = pix_i[PIX_W-1 -: IDX_W];
        g_idx_o = pix_i[G_LSB +: IDX_W];
        b_idx_o = pix_i[IDX_W-1:0];
      end
      default: begin
        r_idx_o = pix_i[IDX_W-1:0];
        g_idx_o = pix_i[IDX_W-1:0];
        b_idx_o = pix_i[IDX_W-1:0];
      end
    endcase
  end
endmodule

// File: rtl/pal_gun_ram.sv
module pal_gun_ram #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned DW    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             pre_i,
  input  logic [IDX_W-1:0] paddr_i,
  output logic [DW-1:0]    pdata_o,
  input  logic             cre_i,
  input  logic [IDX_W-1:0] caddr_i,
  output logic [DW-1:0]    cdata_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  // read-before-write: same-cycle collision yields old entry
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pdata_o <= '0;
      cdata_o <= '0;
    end else begin
      if (pre_i) pdata_o <= mem[paddr_i];
      if (cre_i) cdata_o <= mem[caddr_i];
    end
  end

  a_r7_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem[$past(waddr_i)] == $past(wdata_i));

  a_r12_old_on_collision: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_i && we_i && paddr_i == waddr_i) |=> pdata_o == $past(mem[paddr_i]));
endmodule

// File: rtl/pal_cpu_port.sv
module pal_cpu_port
  import pal_pkg::*;
#(
  parameter int unsigned GUN_W  = 8,
  parameter int unsigned NGUN_W = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic                    re_i,
  input  logic [1:0]              space_i,
  output logic                    wide_we_o,
  output logic                    nar_we_o,
  input  logic [NGUNS*GUN_W-1:0]  wide_rd_i,
  input  logic [NGUNS*NGUN_W-1:0] nar_rd_i,
  output logic [NGUNS*GUN_W-1:0]  rdata_o
);
  space_e sp;
  space_e sel_q;
  logic [NGUNS*GUN_W-1:0] nar_fmt;

  assign sp        = space_e'(space_i);
  assign wide_we_o = we_i && (sp == SP_WIDE || sp == SP_BOTH);
  assign nar_we_o  = we_i && (sp == SP_NARROW || sp == SP_BOTH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sel_q <= SP_NONE;
    else if (re_i) sel_q <= sp;
  end

  for (genvar g = 0; g < NGUNS; g++) begin : g_fmt
    assign nar_fmt[g*GUN_W +: GUN_W] =
      {nar_rd_i[g*NGUN_W +: NGUN_W], {(GUN_W-NGUN_W){1'b0}}};
  end

  always_comb begin
    case (sel_q)
      SP_WIDE:   rdata_o = wide_rd_i;
      SP_NARROW: rdata_o = nar_fmt;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/pal_lookup.sv
module pal_lookup
  import pal_pkg::*;
#(
  parameter int unsigned PIX_W  = 16,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned GUN_W  = 8,
  parameter int unsigned NGUN_W = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [1:0]              mode_i,
  input  logic                    pix_valid_i,
  input  logic [PIX_W-1:0]        pix_i,
  output logic                    color_valid_o,
  output logic [NGUNS*GUN_W-1:0]  vga_color_o,
  output logic [NGUNS*NGUN_W-1:0] lcd_color_o,
  input  logic                    cpu_we_i,
  input  logic                    cpu_re_i,
  input  logic [1:0]              cpu_space_i,
  input  logic [IDX_W-1:0]        cpu_idx_i,
  input  logic [NGUNS*GUN_W-1:0]  cpu_wdata_i,
  output logic [NGUNS*GUN_W-1:0]  cpu_rdata_o
);
  mode_e mode;
  logic [IDX_W-1:0] idx [NGUNS];
  logic wide_we, nar_we;
  logic [NGUNS*GUN_W-1:0]  wide_rd;
  logic [NGUNS*NGUN_W-1:0] nar_rd;

  assign mode = mode_e'(mode_i);

  pal_index #(.PIX_W(PIX_W), .IDX_W(IDX_W)) u_index (
    .mode_i (mode),
    .pix_i  (pix_i),
    .r_idx_o(idx[2]),
    .g_idx_o(idx[1]),
    .b_idx_o(idx[0])
  );

  pal_cpu_port #(.GUN_W(GUN_W), .NGUN_W(NGUN_W)) u_cpu (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cpu_we_i),
    .re_i     (cpu_re_i),
    .space_i  (cpu_space_i),
    .wide_we_o(wide_we),
    .nar_we_o (nar_we),
    .wide_rd_i(wide_rd),
    .nar_rd_i (nar_rd),
    .rdata_o  (cpu_rdata_o)
  );

  for (genvar g = 0; g < NGUNS; g++) begin : g_gun
    pal_gun_ram #(.IDX_W(IDX_W), .DW(GUN_W)) u_wide (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (wide_we),
      .waddr_i(cpu_idx_i),
      .wdata_i(cpu_wdata_i[g*GUN_W +: GUN_W]),
      .pre_i  (pix_valid_i),
      .paddr_i(idx[g]),
      .pdata_o(vga_color_o[g*GUN_W +: GUN_W]),
      .cre_i  (cpu_re_i),
      .caddr_i(cpu_idx_i),
      .cdata_o(wide_rd[g*GUN_W +: GUN_W])
    );
    // narrow palette keeps the upper nibble of each gun byte
    pal_gun_ram #(.IDX_W(IDX_W), .DW(NGUN_W)) u_nar (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (nar_we),
      .waddr_i(cpu_idx_i),
      .wdata_i(cpu_wdata_i[g*GUN_W+GUN_W-NGUN_W +: NGUN_W]),
      .pre_i  (pix_valid_i),
      .paddr_i(idx[g]),
      .pdata_o(lcd_color_o[g*NGUN_W +: NGUN_W]),
      .cre_i  (cpu_re_i),
      .caddr_i(cpu_idx_i),
      .cdata_o(nar_rd[g*NGUN_W +: NGUN_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) color_valid_o <= 1'b0;
    else         color_valid_o <= pix_valid_i;
  end

  a_r6_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_i |=> color_valid_o);
  a_r6_valid_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_i |=> !color_valid_o);
  a_r6_color_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_i |=> $stable(vga_color_o) && $stable(lcd_color_o));
  a_r4_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_16) |-> (idx[2][IDX_W/2-1:0] == idx[1][IDX_W-1 -: IDX_W/2]) &&
                          (idx[1][IDX_W/2-1:0] == idx[0][IDX_W-1 -: IDX_W/2]));
  a_r2_shared_small_idx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_4) |-> (idx[2] == idx[1]) && (idx[1] == idx[0]) &&
                         (idx[0] < IDX_W'(1 << LOW_BPP)));
  a_r11_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_re_i |=> $stable(cpu_rdata_o));
endmodule

// File: tb/tb_pal_lookup.sv
module tb_pal_lookup;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] mode_i = '0;
  logic pix_valid_i = 1'b0;
  logic [15:0] pix_i = '0;
  logic color_valid_o;
  logic [23:0] vga_color_o;
  logic [11:0] lcd_color_o;
  logic cpu_we_i = 1'b0, cpu_re_i = 1'b0;
  logic [1:0] cpu_space_i = '0;
  logic [7:0] cpu_idx_i = '0;
  logic [23:0] cpu_wdata_i = '0;
  logic [23:0] cpu_rdata_o;

  pal_lookup dut (.*);

  always #10 clk_i = ~clk_i;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [23:0] wm [256];
  logic [11:0] nm [256];
  logic [23:0] e_vga = '0, e_rd = '0;
  logic [11:0] e_lcd = '0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic string mtag(logic [1:0] m);
    case (m)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic logic [7:0] gidx(logic [1:0] m, logic [15:0] p, int g);
    if (m == 2'd0) return {4'h0, p[3:0]};
    if (m == 2'd2) return (g == 2) ? p[15:8] : (g == 1) ? p[11:4] : p[7:0];
    return p[7:0];
  endfunction

  // one cycle: drive, predict from pre-write model, update model, sample
  task automatic cyc(logic pv, logic [15:0] p, logic [1:0] m, logic we, logic re,
                     logic [1:0] sp, logic [7:0] ix, logic [23:0] wd, string tag);
    pix_valid_i = pv; pix_i = p; mode_i = m;
    cpu_we_i = we; cpu_re_i = re; cpu_space_i = sp; cpu_idx_i = ix; cpu_wdata_i = wd;
    if (pv) begin
      logic [7:0] ri, gi, bi;
      ri = gidx(m, p, 2); gi = gidx(m, p, 1); bi = gidx(m, p, 0);
      e_vga = {wm[ri][23:16], wm[gi][15:8], wm[bi][7:0]};
      e_lcd = {nm[ri][11:8], nm[gi][7:4], nm[bi][3:0]};
    end
    if (re) begin
      if (sp == 2'd0) e_rd = wm[ix];
      else if (sp == 2'd1) e_rd = {nm[ix][11:8], 4'h0, nm[ix][7:4], 4'h0, nm[ix][3:0], 4'h0};
      else e_rd = '0;
    end
    if (we && (sp == 2'd0 || sp == 2'd2)) wm[ix] = wd;
    if (we && (sp == 2'd1 || sp == 2'd2)) nm[ix] = {wd[23:20], wd[15:12], wd[7:4]};
    @(negedge clk_i);
    chk({tag, " R6 valid"}, 32'(color_valid_o), 32'(pv));
    chk({tag, " R13 vga"}, 32'(vga_color_o), 32'(e_vga));
    chk({tag, " R13 lcd"}, 32'(lcd_color_o), 32'(e_lcd));
    chk({tag, " R11 rdata"}, 32'(cpu_rdata_o), 32'(e_rd));
  endtask

  task automatic idle();
    cyc(0, '0, 2'd1, 0, 0, 2'd0, '0, '0, "idle");
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5a17));
    repeat (3) @(negedge clk_i);
    chk("R1 valid", 32'(color_valid_o), 0);
    chk("R1 vga", 32'(vga_color_o), 0);
    chk("R1 lcd", 32'(lcd_color_o), 0);
    chk("R1 rdata", 32'(cpu_rdata_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 rdata after", 32'(cpu_rdata_o), 0);

    // fill both palettes through the combined space
    for (int i = 0; i < 256; i++) cyc(0, '0, 2'd1, 1, 0, 2'd2, 8'(i), 24'($urandom), "R9 fill");

    // R7: wide-only write; narrow readback unchanged
    cyc(0, '0, 2'd1, 1, 0, 2'd0, 8'h21, 24'hA1B2C3, "R7 wr");
    cyc(0, '0, 2'd1, 0, 1, 2'd0, 8'h21, '0, "R7 rd wide");
    chk("R7 wide", 32'(cpu_rdata_o), 32'h00A1B2C3);
    cyc(0, '0, 2'd1, 0, 1, 2'd1, 8'h21, '0, "R7 rd nar");
    // R8: narrow-only write keeps upper nibbles; wide unchanged
    cyc(0, '0, 2'd1, 1, 0, 2'd1, 8'h21, 24'h5E6F7D, "R8 wr");
    cyc(0, '0, 2'd1, 0, 1, 2'd1, 8'h21, '0, "R8 rd nar");
    chk("R8 nar", 32'(cpu_rdata_o), 32'h00506070);
    cyc(0, '0, 2'd1, 0, 1, 2'd0, 8'h21, '0, "R8 rd wide");
    chk("R8 wide kept", 32'(cpu_rdata_o), 32'h00A1B2C3);
    // R9 both, checked through pixel path too
    cyc(0, '0, 2'd1, 1, 0, 2'd2, 8'h33, 24'h19E7C4, "R9 wr");
    cyc(1, 16'h0033, 2'd1, 0, 0, 2'd0, '0, '0, "R9 pix");
    chk("R9 vga", 32'(vga_color_o), 32'h0019E7C4);
    chk("R9 lcd", 32'(lcd_color_o), 32'h000001EC);
    // R10: reserved space write ignored
    cyc(0, '0, 2'd1, 1, 0, 2'd3, 8'h33, 24'hFFFFFF, "R10 wr");
    cyc(1, 16'h0033, 2'd1, 0, 1, 2'd0, 8'h33, '0, "R10 pix");
    chk("R10 vga", 32'(vga_color_o), 32'h0019E7C4);
    chk("R10 rd", 32'(cpu_rdata_o), 32'h0019E7C4);
    cyc(0, '0, 2'd1, 0, 1, 2'd3, 8'h33, '0, "R11 rd space3 zero");
    chk("R11 zero", 32'(cpu_rdata_o), 0);
    // R2: upper pixel bits ignored in 4bpp
    cyc(1, 16'hFFF3, 2'd0, 0, 0, 2'd0, '0, '0, "R2 upper");
    chk("R2 vga", 32'(vga_color_o), 32'(wm[3]));
    // R12/R11 collisions: pixel and read hit the entry being written
    cyc(1, 16'h0044, 2'd1, 1, 1, 2'd2, 8'h44, 24'h123456, "R12 coll");
    cyc(1, 16'h0044, 2'd1, 0, 0, 2'd0, '0, '0, "R12 after");
    chk("R12 new", 32'(vga_color_o), 32'h00123456);
    // 16bpp collision on green gun only
    cyc(1, 16'h0550, 2'd2, 1, 0, 2'd0, 8'h55, 24'hABCDEF, "R4 coll");
    cyc(1, 16'h0550, 2'd2, 0, 0, 2'd0, '0, '0, "R4 after");
    // R6: hold when no new pixel
    idle(); idle();

    // random traffic, then a narrow-index phase for frequent collisions
    for (int ph = 0; ph < 2; ph++) begin
      for (int n = 0; n < 3000; n++) begin
        logic [1:0] m;
        logic [15:0] p;
        logic [7:0] ix;
        m = 2'($urandom);
        p = 16'($urandom);
        ix = 8'($urandom);
        if (ph == 1) begin
          p = p & 16'h1111;
          ix = ix & 8'h11;
        end
        cyc(1'($urandom), p, m, ($urandom % 3) == 0, 1'($urandom), 2'($urandom),
            ix, 24'($urandom), mtag(m));
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule